// File: doc/BRIEF.md
# Three-Channel Prescaled PWM Timer

This block holds three independent timer channels behind a small word-addressed register bus. Each channel counts ticks of the internal clock. It can divide that clock first by a power of two, in the range 2 to 65536. The counter either runs freely over its full width or wraps at a programmable interval value. A per-channel match value is compared against the count to form a pulse-width modulated output. Software programs the period, the duty and the polarity of that output.

Software sets up a channel by writing the clock setup word, the interval and the match value. It then writes the counter control word with counting and the waveform both enabled and the restart bit set. The channel can then be frozen, resumed, or have its waveform forced to the inactive level, and none of these writes disturbs the count unless a restart is requested. Bus writes take effect at the clock edge on which the strobe is sampled. Read data is returned combinationally while a read strobe is present.

Top module: `tick_pwm_bank`

## Requirements
- R1: Registers sit at byte offsets clock setup 0x00, counter control 0x0C, interval 0x24 and match 0x30, each plus 4×channel for channels 0..2. Clock setup bit 0 is prescale enable, bits 4:1 are prescale code N, and bits 5 and 6 are two spare source/edge flags. All seven bits read back as written, and bits above bit 6 read 0.
- R2: A read of any other offset, including a misaligned one, returns 0. A write to such an offset changes no register and no output.
- R3: Interval and match values keep only their low CNT_W bits. Higher written bits are dropped and read back as 0.
- R4: Counter control bits are: 0 freeze, 1 interval mode, 2 count down, 3 match enable, 4 restart, 5 waveform off, 6 invert. Bit 4 always reads 0. A write with bit 4 set loads the start value at the following clock edge: 0 when counting up, the interval (interval mode) or all ones (free run) when counting down.
- R5: Counting up in interval mode, the count steps 0,1,…,interval and then returns to 0, giving a period of interval+1 ticks.
- R6: With prescale disabled the counter ticks on every clock. With it enabled and code N, it ticks once every 2^(N+1) clocks, counted from the restart.
- R7: With match enabled and invert 0, the output is 1 while count < match and 0 otherwise. Invert 1 complements the output. With match disabled, the output stays at its inactive level, which equals the invert bit.
- R8: Counting down, the count falls to 0 and then reloads the interval (interval mode) or all ones (free run).
- R9: While freeze is set, the count holds its value. Clearing freeze without a restart continues from the held value.
- R10: While waveform off is set, the output equals the invert bit and the counter keeps running.
- R11: With interval mode off, the count wraps at 2^CNT_W−1.
- R12: After reset, counter control reads 0x21 (frozen, waveform off), all other registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counters |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, 0 when no read is present |
| pwmOut | output | 3 | Waveform output per channel |

## Verification
On every cycle, the bound checker confirms several relations. Unmapped reads and restart-bit reads yield zero. A frozen channel keeps its count. A restart loads the correct start value in both directions. A waveform-off write forces the output to the written invert level on the next cycle. Only the bench scenarios can show the waveform shape over whole periods: the prescaled tick spacing, the wrap points in interval and free-running modes, the duty edges across the match values, and the continuation of the phase after a freeze is lifted.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;

  localparam int NUM_CH     = 3;
  localparam int PRE_CODE_W = 4;
  localparam int PRE_CNT_W  = 1 << PRE_CODE_W;

  // byte offsets of channel 0, channel n adds CH_STRIDE*n
  localparam int CH_STRIDE  = 4;
  localparam int CLK_OFS    = 'h00;
  localparam int CTRL_OFS   = 'h0C;
  localparam int IVL_OFS    = 'h24;
  localparam int MATCH_OFS  = 'h30;
  localparam int CLK_WORD   = CLK_OFS / 4;
  localparam int CTRL_WORD  = CTRL_OFS / 4;
  localparam int IVL_WORD   = IVL_OFS / 4;
  localparam int MATCH_WORD = MATCH_OFS / 4;

  // clock setup field positions
  localparam int CK_PRE_EN  = 0;
  localparam int CK_CODE_LO = 1;
  localparam int CK_EXT     = 5;
  localparam int CK_EDGE    = 6;

  // counter control field positions
  localparam int CT_STOP    = 0;
  localparam int CT_IVL     = 1;
  localparam int CT_DOWN    = 2;
  localparam int CT_MATCH   = 3;
  localparam int CT_RESTART = 4;
  localparam int CT_WOFF    = 5;
  localparam int CT_INV     = 6;

  typedef struct packed {
    logic                  preEn;
    logic [PRE_CODE_W-1:0] preCode;
    logic                  extSel;
    logic                  edgeSel;
  } clkCfg_t;

  typedef struct packed {
    logic invert;
    logic waveOff;
    logic matchEn;
    logic countDown;
    logic ivlMode;
    logic cntStop;
  } cntCfg_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic restart;
  } chStrobe_t;

  localparam cntCfg_t CNT_CFG_RST = '{invert: 1'b0, waveOff: 1'b1, matchEn: 1'b0,
                                      countDown: 1'b0, ivlMode: 1'b0, cntStop: 1'b1};

  function automatic logic [7:0] packClk(clkCfg_t c);
    logic [7:0] w;
    w = '0;
    w[CK_PRE_EN] = c.preEn;
    w[CK_CODE_LO +: PRE_CODE_W] = c.preCode;
    w[CK_EXT] = c.extSel;
    w[CK_EDGE] = c.edgeSel;
    return w;
  endfunction

  function automatic logic [7:0] packCtrl(cntCfg_t c);
    logic [7:0] w;
    w = '0;
    w[CT_STOP]  = c.cntStop;
    w[CT_IVL]   = c.ivlMode;
    w[CT_DOWN]  = c.countDown;
    w[CT_MATCH] = c.matchEn;
    w[CT_WOFF]  = c.waveOff;
    w[CT_INV]   = c.invert;
    return w;
  endfunction

endpackage

// File: rtl/tick_pwm_regs.sv
module tick_pwm_regs
  import tick_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busValid,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  output clkCfg_t   [NUM_CH-1:0]           clkCfg,
  output cntCfg_t   [NUM_CH-1:0]           cntCfg,
  output logic      [NUM_CH-1:0][CNT_W-1:0] ivlVal,
  output logic      [NUM_CH-1:0][CNT_W-1:0] matchVal,
  output chStrobe_t [NUM_CH-1:0]           strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic [IDX_W-1:0]  wordIdx;
  logic              wrEn;
  logic              rdEn;
  logic [NUM_CH-1:0] clkHit;
  logic [NUM_CH-1:0] ctrlHit;
  logic [NUM_CH-1:0] ivlHit;
  logic [NUM_CH-1:0] matchHit;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busValid && busWrite;
  assign rdEn    = busValid && !busWrite;

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      clkHit[ch]   = aligned && (int'(wordIdx) == CLK_WORD + ch);
      ctrlHit[ch]  = aligned && (int'(wordIdx) == CTRL_WORD + ch);
      ivlHit[ch]   = aligned && (int'(wordIdx) == IVL_WORD + ch);
      matchHit[ch] = aligned && (int'(wordIdx) == MATCH_WORD + ch);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        clkCfg[ch]   <= '0;
        cntCfg[ch]   <= CNT_CFG_RST;
        ivlVal[ch]   <= '0;
        matchVal[ch] <= '0;
        strobe[ch]   <= '0;
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        // restart acts one edge after the write, with the new control word in place
        strobe[ch].restart <= wrEn && ctrlHit[ch] && busWdata[CT_RESTART];
        if (wrEn && clkHit[ch]) begin
          clkCfg[ch].preEn   <= busWdata[CK_PRE_EN];
          clkCfg[ch].preCode <= busWdata[CK_CODE_LO +: PRE_CODE_W];
          clkCfg[ch].extSel  <= busWdata[CK_EXT];
          clkCfg[ch].edgeSel <= busWdata[CK_EDGE];
        end
        if (wrEn && ctrlHit[ch]) begin
          cntCfg[ch].cntStop   <= busWdata[CT_STOP];
          cntCfg[ch].ivlMode   <= busWdata[CT_IVL];
          cntCfg[ch].countDown <= busWdata[CT_DOWN];
          cntCfg[ch].matchEn   <= busWdata[CT_MATCH];
          cntCfg[ch].waveOff   <= busWdata[CT_WOFF];
          cntCfg[ch].invert    <= busWdata[CT_INV];
        end
        if (wrEn && ivlHit[ch]) begin
          ivlVal[ch] <= busWdata[CNT_W-1:0];
        end
        if (wrEn && matchHit[ch]) begin
          matchVal[ch] <= busWdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (clkHit[ch])   busRdata = DATA_W'(packClk(clkCfg[ch]));
        if (ctrlHit[ch])  busRdata = DATA_W'(packCtrl(cntCfg[ch]));
        if (ivlHit[ch])   busRdata = DATA_W'(ivlVal[ch]);
        if (matchHit[ch]) busRdata = DATA_W'(matchVal[ch]);
      end
    end
  end

endmodule

// File: rtl/tick_pwm_prescaler.sv
module tick_pwm_prescaler
  import tick_pwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  run,
  input  logic                  clear,
  input  logic                  preEn,
  input  logic [PRE_CODE_W-1:0] preCode,
  output logic                  tick
);

  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] mask;

  // code N keeps the low N+1 bits: all ones there once per 2^(N+1) clocks
  assign mask = {PRE_CNT_W{1'b1}} >> (PRE_CODE_W'(PRE_CNT_W - 1) - preCode);
  assign tick = run && (!preEn || ((preCnt & mask) == mask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (clear) begin
      preCnt <= '0;
    end else if (run) begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tick_pwm_datapath.sv
module tick_pwm_datapath
  import tick_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  clkCfg_t   [NUM_CH-1:0]           clkCfg,
  input  cntCfg_t   [NUM_CH-1:0]           cntCfg,
  input  logic      [NUM_CH-1:0][CNT_W-1:0] ivlVal,
  input  logic      [NUM_CH-1:0][CNT_W-1:0] matchVal,
  input  chStrobe_t [NUM_CH-1:0]           strobe,
  output logic      [NUM_CH-1:0][CNT_W-1:0] chCount,
  output logic      [NUM_CH-1:0]           pwmOut
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic             tick;
    logic             running;
    logic             active;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reloadDown;
    logic [CNT_W-1:0] startVal;

    assign running    = !cntCfg[ch].cntStop;
    assign reloadDown = cntCfg[ch].ivlMode ? ivlVal[ch] : {CNT_W{1'b1}};
    assign startVal   = cntCfg[ch].countDown ? reloadDown : '0;

    tick_pwm_prescaler u_pre (
      .clk     (clk),
      .rstN    (rstN),
      .run     (running),
      .clear   (strobe[ch].restart),
      .preEn   (clkCfg[ch].preEn),
      .preCode (clkCfg[ch].preCode),
      .tick    (tick)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        count <= '0;
      end else if (strobe[ch].restart) begin
        count <= startVal;
      end else if (tick) begin
        if (cntCfg[ch].countDown) begin
          count <= (count == '0) ? reloadDown : count - 1'b1;
        end else if (cntCfg[ch].ivlMode && (count == ivlVal[ch])) begin
          count <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end

    assign active      = cntCfg[ch].matchEn && (count < matchVal[ch]);
    assign pwmOut[ch]  = cntCfg[ch].waveOff ? cntCfg[ch].invert
                                            : (active ^ cntCfg[ch].invert);
    assign chCount[ch] = count;
  end

endmodule

// File: rtl/tick_pwm_bank.sv
module tick_pwm_bank
  import tick_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pwmOut
);

  clkCfg_t   [NUM_CH-1:0]            clkCfg;
  cntCfg_t   [NUM_CH-1:0]            cntCfg;
  logic      [NUM_CH-1:0][CNT_W-1:0] ivlVal;
  logic      [NUM_CH-1:0][CNT_W-1:0] matchVal;
  chStrobe_t [NUM_CH-1:0]            strobe;
  logic      [NUM_CH-1:0][CNT_W-1:0] chCount;

  tick_pwm_regs #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .clkCfg   (clkCfg),
    .cntCfg   (cntCfg),
    .ivlVal   (ivlVal),
    .matchVal (matchVal),
    .strobe   (strobe)
  );

  tick_pwm_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .clkCfg   (clkCfg),
    .cntCfg   (cntCfg),
    .ivlVal   (ivlVal),
    .matchVal (matchVal),
    .strobe   (strobe),
    .chCount  (chCount),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/tick_pwm_checker.sv
module tick_pwm_checker
  import tick_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             busValid,
  input logic                             busWrite,
  input logic [ADDR_W-1:0]                busAddr,
  input logic [DATA_W-1:0]                busWdata,
  input logic [DATA_W-1:0]                busRdata,
  input logic [NUM_CH-1:0]                pwmOut,
  input cntCfg_t   [NUM_CH-1:0]           cntCfg,
  input logic      [NUM_CH-1:0][CNT_W-1:0] ivlVal,
  input chStrobe_t [NUM_CH-1:0]           strobe,
  input logic      [NUM_CH-1:0][CNT_W-1:0] chCount
);

  logic mapped;
  int   idx;

  assign idx    = int'(busAddr[ADDR_W-1:2]);
  assign mapped = (busAddr[1:0] == 2'b00) &&
                  ((idx < CTRL_WORD + NUM_CH) ||
                   ((idx >= IVL_WORD) && (idx < MATCH_WORD + NUM_CH)));

  // R2: reads outside the map return zero
  assert_unmapped_read_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !mapped) |-> (busRdata == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    logic ctrlAddr;
    assign ctrlAddr = (int'(busAddr) == CTRL_OFS + CH_STRIDE * ch);

    // R4: restart bit never reads back set
    assert_restart_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && !busWrite && ctrlAddr) |-> !busRdata[CT_RESTART]);

    // R4: restart while counting up starts from zero
    assert_restart_up_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[ch].restart && !cntCfg[ch].countDown) |=> (chCount[ch] == '0));

    // R8: restart while counting down in interval mode loads the interval
    assert_restart_down_ivl_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[ch].restart && cntCfg[ch].countDown && cntCfg[ch].ivlMode)
        |=> (chCount[ch] == $past(ivlVal[ch])));

    // R9: a frozen channel keeps its count
    assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cntCfg[ch].cntStop && !strobe[ch].restart) |=> $stable(chCount[ch]));

    // R10: waveform-off write drives the written invert level next cycle
    assert_wave_off_level_R10: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && busWrite && ctrlAddr && busWdata[CT_WOFF])
        |=> (pwmOut[ch] == $past(busWdata[CT_INV])));
  end

endmodule

bind tick_pwm_bank tick_pwm_checker #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pwmOut   (pwmOut),
  .cntCfg   (cntCfg),
  .ivlVal   (ivlVal),
  .strobe   (strobe),
  .chCount  (chCount)
);

// File: tb/tick_pwm_bank_tb.sv
`timescale 1ns/1ps
module tick_pwm_bank_tb;

  localparam int CNT_W = 6;
  localparam int FULL  = 1 << CNT_W;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busValid;
  logic        busWrite;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [2:0]  pwmOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tick_pwm_bank #(.CNT_W(CNT_W), .ADDR_W(8), .DATA_W(32)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pwmOut   (pwmOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] aClk(int ch);  return 8'(32'h00 + 4 * ch); endfunction
  function automatic logic [7:0] aCtl(int ch);  return 8'(32'h0C + 4 * ch); endfunction
  function automatic logic [7:0] aIvl(int ch);  return 8'(32'h24 + 4 * ch); endfunction
  function automatic logic [7:0] aMat(int ch);  return 8'(32'h30 + 4 * ch); endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic rdCheck(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // expected output after k counter edges since the restart edge
  function automatic logic expOut(int k, int d, bit ivlM, bit down, bit mEn,
                                  bit inv, int ivl, int mt);
    int t = k / d;
    int c;
    if (!down) c = ivlM ? t % (ivl + 1) : t % FULL;
    else       c = ivlM ? ivl - t % (ivl + 1) : FULL - 1 - t % FULL;
    return logic'((mEn && (c < mt)) ^ inv);
  endfunction

  task automatic startCh(int ch, bit preEn, int code, bit ivlM, bit down,
                         bit mEn, bit inv, int ivl, int mt);
    wr(aClk(ch), 32'(int'(preEn) | (code << 1)));
    wr(aIvl(ch), 32'(ivl));
    wr(aMat(ch), 32'(mt));
    wr(aCtl(ch), 32'((int'(ivlM) << 1) | (int'(down) << 2) | (int'(mEn) << 3) |
                     16 | (int'(inv) << 6)));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic runCh(string req, int ch, bit preEn, int code, bit ivlM, bit down,
                       bit mEn, bit inv, int ivl, int mt, int cycles);
    int d = preEn ? (2 << code) : 1;
    startCh(ch, preEn, code, ivlM, down, mEn, inv, ivl, mt);
    for (int k = 0; k < cycles; k++) begin
      check(req, 32'(pwmOut[ch]), 32'(expOut(k, d, ivlM, down, mEn, inv, ivl, mt)));
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(4ns * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k;
    rstN = 1'b0; busValid = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    check("R12 outputs", 32'(pwmOut), 32'h0);
    for (int ch = 0; ch < 3; ch++) begin
      rdCheck("R12 clk", aClk(ch), 32'h0);
      rdCheck("R12 ctrl", aCtl(ch), 32'h21);
      rdCheck("R12 ivl", aIvl(ch), 32'h0);
      rdCheck("R12 match", aMat(ch), 32'h0);
    end

    // R1: clock setup readback including spare flags
    wr(aClk(1), 32'hFFFF_FF7F);
    rdCheck("R1 clk all", aClk(1), 32'h7F);
    wr(aClk(2), 32'h55);
    rdCheck("R1 clk mix", aClk(2), 32'h55);
    rdCheck("R1 clk other", aClk(0), 32'h0);
    // R4: restart reads back 0
    wr(aCtl(2), 32'h5F);
    rdCheck("R4 ctrl readback", aCtl(2), 32'h4F);
    wr(aCtl(2), 32'h21);
    wr(aClk(1), 32'h0);
    wr(aClk(2), 32'h0);

    // R3: truncation
    wr(aIvl(0), 32'h1_0045);
    rdCheck("R3 ivl", aIvl(0), 32'h05);
    wr(aMat(0), 32'hFFFF);
    rdCheck("R3 match", aMat(0), 32'h3F);

    // R2: unmapped reads and writes
    rdCheck("R2 gap", 8'h18, 32'h0);
    rdCheck("R2 top", 8'h3C, 32'h0);
    rdCheck("R2 misaligned", 8'h0E, 32'h0);
    rdCheck("R2 high", 8'hFC, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rdCheck("R2 ctrl kept", aCtl(0), 32'h21);
    rdCheck("R2 ctrl1 kept", aCtl(1), 32'h21);
    rdCheck("R2 ivl kept", aIvl(0), 32'h05);
    check("R2 outputs", 32'(pwmOut), 32'h0);

    // R5 R7: sweep of small intervals and match values, alternating polarity
    for (int iv = 0; iv < 5; iv++)
      for (int mt = 0; mt < 7; mt++)
        runCh("R5 R7 sweep", 0, 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'((iv + mt) & 1),
              iv, mt, 2 * (iv + 1) + 2);

    // R6: prescaled ticks
    runCh("R6 div4", 1, 1'b1, 1, 1'b1, 1'b0, 1'b1, 1'b1, 5, 3, 60);
    runCh("R6 div2 R8", 2, 1'b1, 0, 1'b1, 1'b1, 1'b1, 1'b0, 7, 3, 40);
    runCh("R6 div8", 0, 1'b1, 2, 1'b1, 1'b0, 1'b1, 1'b0, 3, 2, 70);

    // R8: down count in interval mode
    runCh("R8 down", 1, 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 6, 4, 20);

    // R11: free-running wrap both directions
    runCh("R11 up free", 0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 40, 140);
    runCh("R11 down free", 1, 1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 10, 140);

    // R7: match disabled holds the inactive level
    runCh("R7 no match", 2, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1, 5, 3, 20);
    runCh("R7 no match pol0", 2, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 5, 3, 12);

    // R9: freeze at count 7 just below match 8, then resume
    startCh(1, 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 15, 8);
    k = 0;
    for (int i = 0; i < 6; i++) begin
      check("R9 before", 32'(pwmOut[1]), 32'(expOut(k, 1, 1, 0, 1, 0, 15, 8)));
      @(posedge clk); @(negedge clk);
      k++;
    end
    wr(aCtl(1), 32'h0B);
    k++;
    for (int i = 0; i < 8; i++) begin
      check("R9 frozen", 32'(pwmOut[1]), 32'(expOut(k, 1, 1, 0, 1, 0, 15, 8)));
      @(posedge clk); @(negedge clk);
    end
    wr(aCtl(1), 32'h0A);
    for (int i = 0; i < 20; i++) begin
      check("R9 resumed", 32'(pwmOut[1]), 32'(expOut(k, 1, 1, 0, 1, 0, 15, 8)));
      @(posedge clk); @(negedge clk);
      k++;
    end

    // R10: waveform off holds the inactive level while counting continues
    startCh(2, 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 9, 5);
    wr(aCtl(2), 32'h6A);
    for (int i = 0; i < 12; i++) begin
      check("R10 off inv1", 32'(pwmOut[2]), 32'h1);
      @(posedge clk); @(negedge clk);
    end
    wr(aCtl(2), 32'h2A);
    for (int i = 0; i < 12; i++) begin
      check("R10 off inv0", 32'(pwmOut[2]), 32'h0);
      @(posedge clk); @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule